// File: doc/BRIEF.md
# Stereo ADC Peak Level Meter

This block sits beside the output of a stereo analog-to-digital converter and tracks, separately for each channel, the loudest sample seen since software last looked at that channel. Each incoming two's-complement sample is turned into a magnitude. A larger magnitude replaces the one held in the channel's peak register, and a smaller one is dropped.

The held peak is presented as a 6-bit attenuation code in 1 dB steps below full scale. Code 0 is the loudest and code 63 means -63 dB or quieter. A control port reads a channel by pulsing that channel's read strobe for one cycle. The code visible in that cycle is the returned value. From the next cycle on, the register starts a fresh tracking interval.

The thresholds are computed from the parameters when the design is built, and 63 comparators work in parallel. The code therefore follows the stored peak in the same cycle, with no search latency.

Top module: `adc_peak_meter`

## Requirements
- R1: The two channels are independent: a sample or read strobe on one channel never changes the code of the other channel.
- R2: With T(n) = floor(2^23 * 10^(-(n+1)/20)) for n = 0..62, the output code is 0 when the held magnitude is at least T(0), n when it is at least T(n) and below T(n-1), and 63 when it is below T(62).
- R3: While no read occurs, the held magnitude is the largest magnitude of all valid samples since the last read, so a smaller later sample never raises the code.
- R4: When rd_stb[c] is high for one cycle, pk_db[c] in that cycle shows the code for the interval just ended. If no sample arrives in that cycle, pk_db[c] is 63 from the next cycle on.
- R5: The magnitude of a sample is its absolute value, and the most negative code -2^23 is treated as 2^23-1, so that it reports code 0.
- R6: A valid sample in the same cycle as a read belongs to the new interval: the returned code excludes it, and from the next cycle the code reflects that sample alone.
- R7: During and after reset, both channels report code 63.
- R8: A sample presented with its valid strobe low has no effect on the code.
- R9: A valid sample updates the channel's code from the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_vld | input | 2 | Per-channel sample valid strobe, bit 0 left, bit 1 right |
| smp_data | input | 48 | Per-channel 24-bit two's-complement sample, channel c at bits [24c+23:24c] |
| rd_stb | input | 2 | Per-channel read strobe from the control port |
| pk_db | output | 12 | Per-channel 6-bit peak code in dB below full scale, channel c at bits [6c+5:6c] |

## Verification
On every cycle the assertions check four things: the held peak never falls without a read; a read with no sample leaves code 63; a read that coincides with a sample keeps exactly that sample; and an idle channel keeps its code. They cannot show that the dB boundaries sit at the right magnitudes, or that negative and saturated samples fold correctly. The bench shows these with a sweep that places a sample exactly on and one below every threshold, for both signs and for both channels. Separate scenarios cover samples while the valid strobe is low, a sample that coincides with a read, and the isolation between the two channels.

// File: rtl/adcpk_pkg.sv
package adcpk_pkg;

  localparam int SMP_W  = 24;
  localparam int CODE_W = 6;
  localparam int STEPS  = 64;
  localparam int NUM_CH = 2;

  // Magnitude threshold of step n: full scale (2^(w-1)) attenuated by (n+1) dB.
  function automatic int unsigned step_thr(input int n, input int w);
    real lvl;
    lvl = (2.0 ** (w - 1)) * (10.0 ** (-(n + 1) / 20.0));
    return $rtoi(lvl);
  endfunction

endpackage

// File: rtl/adcpk_rst_sync.sv
module adcpk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/adcpk_mag.sv
module adcpk_mag #(
  parameter int SMP_W = 24,
  localparam int MAG_W = SMP_W - 1
) (
  input  logic [SMP_W-1:0] smp,
  output logic [MAG_W-1:0] mag
);

  logic [SMP_W-1:0] neg;
  logic             is_min;

  always_comb begin
    neg    = ~smp + 1'b1;
    is_min = smp[SMP_W-1] && (smp[MAG_W-1:0] == '0);
    if (is_min)              mag = '1;                 // R5 saturate
    else if (smp[SMP_W-1])   mag = neg[MAG_W-1:0];
    else                     mag = smp[MAG_W-1:0];
  end

endmodule

// File: rtl/adcpk_track.sv
module adcpk_track #(
  parameter int MAG_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic [MAG_W-1:0] mag,
  input  logic             rd,
  output logic [MAG_W-1:0] peak
);

  logic [MAG_W-1:0] peak_q;
  logic [MAG_W-1:0] peak_nxt;
  logic             peak_en;
  logic             grow;

  always_comb begin
    grow     = vld && (mag > peak_q);
    peak_en  = rd || grow;
    if (rd) peak_nxt = vld ? mag : '0;   // R6 sample joins new interval
    else    peak_nxt = mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       peak_q <= '0;
    else if (peak_en) peak_q <= peak_nxt;
  end

  assign peak = peak_q;

  a_r3_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> peak_q >= $past(peak_q));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !vld) |=> $stable(peak_q));

  a_r6_read_keeps_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && vld) |=> peak_q == $past(mag));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !vld) |=> peak_q == '0);

endmodule

// File: rtl/adcpk_log.sv
module adcpk_log #(
  parameter int MAG_W  = 23,
  parameter int CODE_W = 6,
  parameter int STEPS  = 64,
  localparam int N_CMP = STEPS - 1
) (
  input  logic [MAG_W-1:0]  mag,
  output logic [CODE_W-1:0] code
);

  logic [N_CMP-1:0] below;

  for (genvar n = 0; n < N_CMP; n++) begin : g_cmp
    localparam logic [MAG_W-1:0] THR = MAG_W'(adcpk_pkg::step_thr(n, MAG_W + 1));
    assign below[n] = (mag < THR);
  end

  // Thresholds fall with n, so the count of thresholds above the magnitude is the code.
  always_comb begin
    code = '0;
    for (int n = 0; n < N_CMP; n++) begin
      code = code + CODE_W'(below[n]);
    end
  end

endmodule

// File: rtl/adc_peak_meter.sv
module adc_peak_meter #(
  parameter int SMP_W  = adcpk_pkg::SMP_W,
  parameter int CODE_W = adcpk_pkg::CODE_W,
  parameter int STEPS  = adcpk_pkg::STEPS,
  parameter int NUM_CH = adcpk_pkg::NUM_CH,
  localparam int MAG_W = SMP_W - 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CH-1:0]              smp_vld,
  input  logic [NUM_CH-1:0][SMP_W-1:0]   smp_data,
  input  logic [NUM_CH-1:0]              rd_stb,
  output logic [NUM_CH-1:0][CODE_W-1:0]  pk_db
);

  localparam logic [CODE_W-1:0] QUIET = CODE_W'(STEPS - 1);

  logic srst_n;

  adcpk_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] peak;

    adcpk_mag #(.SMP_W(SMP_W)) u_mag (
      .smp (smp_data[c]),
      .mag (mag)
    );

    adcpk_track #(.MAG_W(MAG_W)) u_trk (
      .clk   (clk),
      .rst_n (srst_n),
      .vld   (smp_vld[c]),
      .mag   (mag),
      .rd    (rd_stb[c]),
      .peak  (peak)
    );

    adcpk_log #(.MAG_W(MAG_W), .CODE_W(CODE_W), .STEPS(STEPS)) u_log (
      .mag  (peak),
      .code (pk_db[c])
    );

    a_r4_empty_read: assert property (@(posedge clk) disable iff (!srst_n)
      (rd_stb[c] && !smp_vld[c]) |=> pk_db[c] == QUIET);

    a_r1_ch_isolated: assert property (@(posedge clk) disable iff (!srst_n)
      (!rd_stb[c] && !smp_vld[c]) |=> $stable(pk_db[c]));

    a_r3_code_no_rise: assert property (@(posedge clk) disable iff (!srst_n)
      !rd_stb[c] |=> pk_db[c] <= $past(pk_db[c]));
  end

endmodule

// File: tb/test_adc_peak_meter.sv
module test_adc_peak_meter;

  localparam int CLK_P  = 10;
  localparam int W      = 24;
  localparam int CW     = 6;
  localparam int NCH    = 2;

  logic                    clk;
  logic                    rst_n;
  logic [NCH-1:0]          smp_vld;
  logic [NCH-1:0][W-1:0]   smp_data;
  logic [NCH-1:0]          rd_stb;
  logic [NCH-1:0][CW-1:0]  pk_db;

  int tests;
  int fails;
  bit done;

  adc_peak_meter i_adc_peak_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .smp_data (smp_data),
    .rd_stb   (rd_stb),
    .pk_db    (pk_db)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic int thr(input int n);
    real v;
    v = (2.0 ** (W - 1)) * (10.0 ** (-(n + 1) / 20.0));
    return $rtoi(v);
  endfunction

  function automatic int exp_code(input int m);
    int c = 0;
    for (int n = 0; n < 63; n++) if (m < thr(n)) c++;
    return c;
  endfunction

  task automatic check(input int ch, input int exp, input string req);
    tests++;
    if (int'(pk_db[ch]) != exp) begin
      fails++;
      $display("FAIL %s ch%0d: got %0d expected %0d", req, ch, pk_db[ch], exp);
    end
  endtask

  task automatic send(input int ch, input int val);
    @(negedge clk);
    smp_vld[ch]  = 1'b1;
    smp_data[ch] = W'(val);
    @(negedge clk);
    smp_vld[ch]  = 1'b0;
  endtask

  // Pulses a read at the current negedge; checks returned code, then the cleared code.
  task automatic rd_check(input int ch, input int exp, input string req);
    rd_stb[ch] = 1'b1;
    check(ch, exp, req);
    @(negedge clk);
    rd_stb[ch] = 1'b0;
    check(ch, 63, "R4");
  endtask

  initial begin
    tests = 0; fails = 0; done = 0;
    rst_n = 1'b0; smp_vld = '0; smp_data = '0; rd_stb = '0;
    repeat (3) @(negedge clk);
    check(0, 63, "R7"); check(1, 63, "R7");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(0, 63, "R7"); check(1, 63, "R7");

    // R2 sweep: on and just below every threshold, both signs, both channels.
    for (int ch = 0; ch < NCH; ch++) begin
      for (int n = 0; n < 64; n++) begin
        send(ch, thr(n));
        rd_check(ch, exp_code(thr(n)), "R2");
        send(ch, -(thr(n) - 1));
        rd_check(ch, exp_code(thr(n) - 1), "R2");
        check(1 - ch, 63, "R1");
      end
    end

    // R5: extremes
    send(0, -(1 << (W - 1)));
    rd_check(0, 0, "R5");
    send(1, (1 << (W - 1)) - 1);
    rd_check(1, 0, "R5");
    send(0, 0);
    rd_check(0, 63, "R5");

    // R3: large then small keeps large
    send(0, thr(5));
    send(0, thr(40));
    send(0, -thr(20));
    rd_check(0, 5, "R3");

    // R9: code visible after capture edge
    @(negedge clk);
    smp_vld[1] = 1'b1; smp_data[1] = W'(thr(10));
    check(1, 63, "R9");
    @(negedge clk);
    smp_vld[1] = 1'b0;
    check(1, 10, "R9");
    rd_check(1, 10, "R9");

    // R8: invalid samples ignored
    @(negedge clk);
    smp_data[0] = W'(thr(0));
    repeat (3) @(negedge clk);
    check(0, 63, "R8");
    send(0, thr(30));
    @(negedge clk);
    smp_data[0] = W'(-thr(1));
    @(negedge clk);
    check(0, 30, "R8");

    // R6: sample coinciding with read goes to new interval
    rd_stb[0] = 1'b1; smp_vld[0] = 1'b1; smp_data[0] = W'(thr(12));
    check(0, 30, "R6");
    @(negedge clk);
    rd_stb[0] = 1'b0; smp_vld[0] = 1'b0;
    check(0, 12, "R6");
    rd_check(0, 12, "R6");

    // R1: activity on channel 1 leaves channel 0 untouched
    send(0, thr(50));
    send(1, thr(2));
    rd_check(1, 2, "R1");
    check(0, 50, "R1");
    rd_check(0, 50, "R1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule